// File: doc/BRIEF.md
# Fast System-Call Transition Unit

This block keeps the architectural state that a 64-bit core changes when it takes a fast kernel call or its matching fast return. The call and return paths read no descriptor tables in memory. Every target comes from a small bank of model-specific registers that software programs by 32-bit index. Those registers hold the feature-enable bits, a packed selector word, the long-mode and compatibility entry addresses, and a flags mask. The selector word holds two base selectors. The unit forms the adjacent code and stack selectors by adding fixed steps to those bases.

The surrounding pipeline loads the current instruction pointer, flags, RCX and R11 through a context port. It then raises a call or return request. Each request finishes at the next clock edge with exactly one of three outputs: a done strobe, an invalid-opcode fault, or a protection fault. A rejected request leaves the state untouched. The long-mode-active flag is read-only. It follows long-mode-enable ANDed with the paging input, one clock later.

Top module: `fastcall_unit`

## Requirements
- R1: After reset the state reads: rip 0, rflags 0x2, cs 0, ss 0, cpl 3, rcx 0, r11 0. Every model-specific register reads zero, and done, ud_fault and gp_fault are low.
- R2: The registers sit at these indices: 0xC0000080 features, 0xC0000081 selectors, 0xC0000082 long-mode entry, 0xC0000083 compatibility entry, 0xC0000084 flags mask. The selector and both entry registers keep all 64 written bits, and msr_rdata shows them combinationally.
- R3: In the feature register only bit 0 (fast-call enable), bit 8 (long-mode enable) and bit 11 (no-execute enable) are writable. Bit 10 (long mode active) is read-only and equals bit 8 AND pg_en, registered one clock later. A write to bit 10 is ignored, and every other bit reads 0.
- R4: The upper 32 bits of the flags mask are reserved. A write to them is ignored and they read zero.
- R5: A read or write at any other index raises msr_err while msr_re or msr_we is high. Such a read returns zero, and such a write changes no register.
- R6: An accepted call sets rcx to the old rip, r11 to the old rflags and rip to the long-mode entry register. It clears rflags wherever the low 32 bits of the mask are one.
- R7: An accepted call sets cs to selector bits 47:32 with bits 1:0 cleared, ss to that value plus 8, and cpl to 0.
- R8: An accepted return with ret_64 = 1 sets cs to (bits 63:48 + 16) | 3, ss to (bits 63:48 + 8) | 3, rip to rcx and cpl to 3.
- R9: An accepted return with ret_64 = 0 sets cs to bits 63:48 | 3, ss to (bits 63:48 + 8) | 3, and rip to rcx[31:0] zero-extended.
- R10: An accepted return sets rflags to r11 with bit 1 forced to one, and leaves rcx and r11 unchanged.
- R11: A request made while fast-call enable or long mode active is 0 gives a one-clock ud_fault and no state change.
- R12: A return requested at cpl 3, with the feature usable, gives a one-clock gp_fault and no state change.
- R13: A request takes effect at the next clock edge. An accepted request pulses done for one clock. If call_req and ret_req are high together the call wins, and a request wins over a context write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_en | input | 1 | Paging enabled; gates the long-mode-active flag |
| msr_we | input | 1 | Register write strobe |
| msr_re | input | 1 | Register read strobe (used only for msr_err) |
| msr_idx | input | 32 | Register index |
| msr_wdata | input | 64 | Register write data |
| msr_rdata | output | 64 | Register read data, combinational |
| msr_err | output | 1 | Access to an undefined index |
| ctx_we | input | 1 | Load rip, rflags, rcx and r11 from the context inputs |
| ctx_rip | input | 64 | Context instruction pointer |
| ctx_rflags | input | 64 | Context flags |
| ctx_rcx | input | 64 | Context RCX |
| ctx_r11 | input | 64 | Context R11 |
| call_req | input | 1 | Fast call request |
| ret_req | input | 1 | Fast return request |
| ret_64 | input | 1 | 1 = return to 64-bit code, 0 = return to compatibility code |
| rip | output | 64 | Instruction pointer |
| rflags | output | 64 | Flags |
| rcx | output | 64 | Saved return address register |
| r11 | output | 64 | Saved flags register |
| cs | output | 16 | Code selector |
| ss | output | 16 | Stack selector |
| cpl | output | 2 | Current privilege level |
| done | output | 1 | Request accepted (one-clock pulse) |
| ud_fault | output | 1 | Invalid-opcode fault (one-clock pulse) |
| gp_fault | output | 1 | Protection fault (one-clock pulse) |

## Verification
Some checks run on every cycle. At most one result strobe is high at a time. An accepted call always lands in ring 0 at the long-mode entry address, with rcx holding the previous rip. An accepted return always lands in ring 3 with both selectors' low bits set and flags bit 1 set. A rejected request always leaves rip and cpl unchanged, and reserved mask bits never read back. Only the directed scenarios can show the following: the exact selector arithmetic for each return flavour, the compatibility truncation, the one-clock lag of the long-mode-active flag behind its enable and the paging input, the masking of specific flag bits, and the call-over-return priority.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int XLEN     = 64;
    localparam int SEL_W    = 16;
    localparam int IDX_W    = 32;
    localparam int MASK_W   = 32;
    localparam int SEL_STEP = 8;

    localparam logic [IDX_W-1:0] IDX_FEAT  = 32'hC000_0080;
    localparam logic [IDX_W-1:0] IDX_SEL   = 32'hC000_0081;
    localparam logic [IDX_W-1:0] IDX_LENT  = 32'hC000_0082;
    localparam logic [IDX_W-1:0] IDX_CENT  = 32'hC000_0083;
    localparam logic [IDX_W-1:0] IDX_FMASK = 32'hC000_0084;

    localparam int FEAT_FAST = 0;
    localparam int FEAT_LME  = 8;
    localparam int FEAT_LMA  = 10;
    localparam int FEAT_NX   = 11;

    localparam int SEL_CALL_LSB = 32;
    localparam int SEL_RET_LSB  = 48;

    localparam logic [XLEN-1:0] FLAGS_RESET = 64'h2;

    typedef struct packed {
        logic [XLEN-1:0]  rip;
        logic [XLEN-1:0]  rflags;
        logic [XLEN-1:0]  rcx;
        logic [XLEN-1:0]  r11;
        logic [SEL_W-1:0] cs;
        logic [SEL_W-1:0] ss;
        logic [1:0]       cpl;
    } arch_t;

    typedef struct packed {
        logic              fast_en;
        logic              lme;
        logic              lma;
        logic              nx_en;
        logic [XLEN-1:0]   sel_word;
        logic [XLEN-1:0]   long_entry;
        logic [XLEN-1:0]   compat_entry;
        logic [MASK_W-1:0] flag_mask;
    } msr_t;
endpackage

// File: rtl/fc_msr_bank.sv
module fc_msr_bank
    import fc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pg_en,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  wdata,
    output msr_t             msr,
    output logic [XLEN-1:0]  rdata,
    output logic             hit
);
    msr_t msr_d, msr_q;

    always_comb begin
        msr_d     = msr_q;
        msr_d.lma = msr_q.lme & pg_en;
        if (we) begin
            unique case (idx)
                IDX_FEAT: begin
                    msr_d.fast_en = wdata[FEAT_FAST];
                    msr_d.lme     = wdata[FEAT_LME];
                    msr_d.nx_en   = wdata[FEAT_NX];
                end
                IDX_SEL:   msr_d.sel_word     = wdata;
                IDX_LENT:  msr_d.long_entry   = wdata;
                IDX_CENT:  msr_d.compat_entry = wdata;
                IDX_FMASK: msr_d.flag_mask    = wdata[MASK_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) msr_q <= '0;
        else        msr_q <= msr_d;
    end

    always_comb begin
        rdata = '0;
        hit   = 1'b1;
        unique case (idx)
            IDX_FEAT: begin
                rdata[FEAT_FAST] = msr_q.fast_en;
                rdata[FEAT_LME]  = msr_q.lme;
                rdata[FEAT_LMA]  = msr_q.lma;
                rdata[FEAT_NX]   = msr_q.nx_en;
            end
            IDX_SEL:   rdata = msr_q.sel_word;
            IDX_LENT:  rdata = msr_q.long_entry;
            IDX_CENT:  rdata = msr_q.compat_entry;
            IDX_FMASK: rdata[MASK_W-1:0] = msr_q.flag_mask;
            default:   hit = 1'b0;
        endcase
    end

    assign msr = msr_q;
endmodule

// File: rtl/fc_xfer.sv
module fc_xfer
    import fc_pkg::*;
(
    input  arch_t cur,
    input  msr_t  msr,
    input  logic  call_req,
    input  logic  ret_req,
    input  logic  ret_64,
    output arch_t nxt,
    output logic  accept,
    output logic  ud,
    output logic  gp
);
    localparam logic [SEL_W-1:0] RPL3 = SEL_W'(3);

    logic             usable, do_call, do_ret, ret_ok;
    logic [SEL_W-1:0] kern_sel, ret_base;

    always_comb begin
        usable   = msr.fast_en & msr.lma;
        do_call  = call_req;
        do_ret   = ret_req & ~call_req;
        ret_ok   = do_ret & usable & (cur.cpl == 2'd0);
        ud       = (do_call | do_ret) & ~usable;
        gp       = do_ret & usable & (cur.cpl != 2'd0);
        accept   = (do_call & usable) | ret_ok;
        kern_sel = msr.sel_word[SEL_CALL_LSB +: SEL_W] & ~RPL3;
        ret_base = msr.sel_word[SEL_RET_LSB +: SEL_W];

        nxt = cur;
        if (do_call && usable) begin
            nxt.rcx    = cur.rip;
            nxt.r11    = cur.rflags;
            nxt.rip    = msr.long_entry;
            nxt.rflags = cur.rflags & ~{{(XLEN-MASK_W){1'b0}}, msr.flag_mask};
            nxt.cs     = kern_sel;
            nxt.ss     = kern_sel + SEL_W'(SEL_STEP);
            nxt.cpl    = 2'd0;
        end else if (ret_ok) begin
            nxt.rflags = cur.r11 | FLAGS_RESET;
            nxt.ss     = (ret_base + SEL_W'(SEL_STEP)) | RPL3;
            nxt.cpl    = 2'd3;
            if (ret_64) begin
                nxt.rip = cur.rcx;
                nxt.cs  = (ret_base + SEL_W'(2*SEL_STEP)) | RPL3;
            end else begin
                nxt.rip = {{(XLEN-32){1'b0}}, cur.rcx[31:0]};
                nxt.cs  = ret_base | RPL3;
            end
        end
    end
endmodule

// File: rtl/fastcall_unit.sv
module fastcall_unit
    import fc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pg_en,
    input  logic        msr_we,
    input  logic        msr_re,
    input  logic [31:0] msr_idx,
    input  logic [63:0] msr_wdata,
    output logic [63:0] msr_rdata,
    output logic        msr_err,
    input  logic        ctx_we,
    input  logic [63:0] ctx_rip,
    input  logic [63:0] ctx_rflags,
    input  logic [63:0] ctx_rcx,
    input  logic [63:0] ctx_r11,
    input  logic        call_req,
    input  logic        ret_req,
    input  logic        ret_64,
    output logic [63:0] rip,
    output logic [63:0] rflags,
    output logic [63:0] rcx,
    output logic [63:0] r11,
    output logic [15:0] cs,
    output logic [15:0] ss,
    output logic [1:0]  cpl,
    output logic        done,
    output logic        ud_fault,
    output logic        gp_fault
);
    typedef struct packed {
        arch_t arch;
        logic  done;
        logic  ud;
        logic  gp;
    } state_t;

    state_t state_d, state_q;
    msr_t   msr;
    arch_t  xfer_nxt;
    logic   accept, ud, gp, hit;

    logic [63:0] long_entry_w;
    logic        fast_en_w, lma_w;

    fc_msr_bank u_msr (
        .clk   (clk),
        .rst_n (rst_n),
        .pg_en (pg_en),
        .we    (msr_we),
        .idx   (msr_idx),
        .wdata (msr_wdata),
        .msr   (msr),
        .rdata (msr_rdata),
        .hit   (hit)
    );

    fc_xfer u_xfer (
        .cur      (state_q.arch),
        .msr      (msr),
        .call_req (call_req),
        .ret_req  (ret_req),
        .ret_64   (ret_64),
        .nxt      (xfer_nxt),
        .accept   (accept),
        .ud       (ud),
        .gp       (gp)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = accept;
        state_d.ud   = ud;
        state_d.gp   = gp;
        if (accept) begin
            state_d.arch = xfer_nxt;
        end else if (ctx_we && !call_req && !ret_req) begin
            state_d.arch.rip    = ctx_rip;
            state_d.arch.rflags = ctx_rflags;
            state_d.arch.rcx    = ctx_rcx;
            state_d.arch.r11    = ctx_r11;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q             <= '0;
            state_q.arch.rflags <= FLAGS_RESET;
            state_q.arch.cpl    <= 2'd3;
        end else begin
            state_q <= state_d;
        end
    end

    assign msr_err      = (msr_we | msr_re) & ~hit;
    assign rip          = state_q.arch.rip;
    assign rflags       = state_q.arch.rflags;
    assign rcx          = state_q.arch.rcx;
    assign r11          = state_q.arch.r11;
    assign cs           = state_q.arch.cs;
    assign ss           = state_q.arch.ss;
    assign cpl          = state_q.arch.cpl;
    assign done         = state_q.done;
    assign ud_fault     = state_q.ud;
    assign gp_fault     = state_q.gp;
    assign long_entry_w = msr.long_entry;
    assign fast_en_w    = msr.fast_en;
    assign lma_w        = msr.lma;
endmodule

// File: rtl/fastcall_unit_chk.sv
module fastcall_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        call_req,
    input logic        ret_req,
    input logic        fast_en,
    input logic        lma,
    input logic [63:0] long_entry,
    input logic [63:0] rip,
    input logic [63:0] rcx,
    input logic [63:0] rflags,
    input logic [15:0] cs,
    input logic [15:0] ss,
    input logic [1:0]  cpl,
    input logic        done,
    input logic        ud_fault,
    input logic        gp_fault,
    input logic        msr_re,
    input logic [31:0] msr_idx,
    input logic [63:0] msr_rdata
);
    // R13: only one result strobe per request
    a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, ud_fault, gp_fault}));

    // R6 and R7: accepted call lands in ring 0 at the entry address
    a_r6_call_target: assert property (@(posedge clk) disable iff (!rst_n)
        $past(call_req && fast_en && lma) |->
            (cpl == 2'd0) && (rip == $past(long_entry)) && (rcx == $past(rip)) && done);

    // R8 and R10: accepted return lands in ring 3 with RPL 3 selectors
    a_r10_ret_ring3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ret_req && !call_req && fast_en && lma && (cpl == 2'd0)) |->
            (cpl == 2'd3) && (cs[1:0] == 2'b11) && (ss[1:0] == 2'b11) && rflags[1] && done);

    // R11: unusable feature faults and freezes state
    a_r11_ud_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $past((call_req || ret_req) && !(fast_en && lma)) |->
            ud_fault && $stable(rip) && $stable(cpl));

    // R12: return from ring 3 faults and keeps ring 3
    a_r12_gp_ring3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ret_req && !call_req && fast_en && lma && (cpl == 2'd3)) |->
            gp_fault && (cpl == 2'd3) && $stable(rip));

    // R4: reserved mask half never reads back
    a_r4_mask_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_re && (msr_idx == 32'hC000_0084)) |-> (msr_rdata[63:32] == 32'h0));
endmodule

bind fastcall_unit fastcall_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_req   (call_req),
    .ret_req    (ret_req),
    .fast_en    (fast_en_w),
    .lma        (lma_w),
    .long_entry (long_entry_w),
    .rip        (rip),
    .rcx        (rcx),
    .rflags     (rflags),
    .cs         (cs),
    .ss         (ss),
    .cpl        (cpl),
    .done       (done),
    .ud_fault   (ud_fault),
    .gp_fault   (gp_fault),
    .msr_re     (msr_re),
    .msr_idx    (msr_idx),
    .msr_rdata  (msr_rdata)
);

// File: tb/fastcall_unit_tb.sv
module fastcall_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_en = 1'b0;
    logic        msr_we = 1'b0, msr_re = 1'b0;
    logic [31:0] msr_idx = '0;
    logic [63:0] msr_wdata = '0;
    logic [63:0] msr_rdata;
    logic        msr_err;
    logic        ctx_we = 1'b0;
    logic [63:0] ctx_rip = '0, ctx_rflags = '0, ctx_rcx = '0, ctx_r11 = '0;
    logic        call_req = 1'b0, ret_req = 1'b0, ret_64 = 1'b0;
    logic [63:0] rip, rflags, rcx, r11;
    logic [15:0] cs, ss;
    logic [1:0]  cpl;
    logic        done, ud_fault, gp_fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [63:0] m_rip = 0, m_fl = 64'h2, m_rcx = 0, m_r11 = 0;
    logic [15:0] m_cs = 0, m_ss = 0;
    logic [1:0]  m_cpl = 2'd3;

    localparam logic [63:0] SELW  = 64'h0018_0013_DEAD_BEEF;
    localparam logic [63:0] LENT  = 64'hFFFF_FFFF_8100_0000;
    localparam logic [63:0] CENT  = 64'h0000_7FFF_0000_1230;
    localparam logic [63:0] FMASK = 64'hFFFF_FFFF_0000_0700;

    always #10 clk = ~clk;

    fastcall_unit u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_arch(input string tag);
        chk({tag, " rip"}, rip, m_rip);
        chk({tag, " rflags"}, rflags, m_fl);
        chk({tag, " rcx"}, rcx, m_rcx);
        chk({tag, " r11"}, r11, m_r11);
        chk({tag, " cs"}, {48'h0, cs}, {48'h0, m_cs});
        chk({tag, " ss"}, {48'h0, ss}, {48'h0, m_ss});
        chk({tag, " cpl"}, {62'h0, cpl}, {62'h0, m_cpl});
    endtask

    task automatic chk_strobes(input string tag, input logic d, input logic u, input logic g);
        chk({tag, " strobes"}, {61'h0, done, ud_fault, gp_fault}, {61'h0, d, u, g});
    endtask

    task automatic wr(input logic [31:0] idx, input logic [63:0] data, output logic err);
        @(negedge clk);
        msr_we = 1'b1; msr_idx = idx; msr_wdata = data;
        #1 err = msr_err;
        @(negedge clk);
        msr_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] idx, output logic [63:0] data, output logic err);
        @(negedge clk);
        msr_re = 1'b1; msr_idx = idx;
        #1 data = msr_rdata; err = msr_err;
        msr_re = 1'b0;
    endtask

    task automatic ctx(input logic [63:0] a, input logic [63:0] f, input logic [63:0] c, input logic [63:0] r);
        @(negedge clk);
        ctx_we = 1'b1; ctx_rip = a; ctx_rflags = f; ctx_rcx = c; ctx_r11 = r;
        @(negedge clk);
        ctx_we = 1'b0;
        m_rip = a; m_fl = f; m_rcx = c; m_r11 = r;
    endtask

    task automatic fire(input logic c, input logic r, input logic r64);
        @(negedge clk);
        call_req = c; ret_req = r; ret_64 = r64;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected effect of an accepted call, from R6 and R7
    task automatic model_call();
        m_rcx = m_rip;
        m_r11 = m_fl;
        m_rip = LENT;
        m_fl  = m_fl & ~{32'h0, FMASK[31:0]};
        m_cs  = SELW[47:32] & 16'hFFFC;
        m_ss  = (SELW[47:32] & 16'hFFFC) + 16'd8;
        m_cpl = 2'd0;
    endtask

    task automatic t_reset();
        logic [63:0] d; logic e;
        chk_arch("R1 reset");
        chk_strobes("R1 reset", 0, 0, 0);
        rd(32'hC000_0080, d, e);
        chk("R1 feature reg at reset", d, 64'h0);
        rd(32'hC000_0082, d, e);
        chk("R1 entry reg at reset", d, 64'h0);
    endtask

    task automatic t_map();
        logic [63:0] d; logic e;
        wr(32'hC000_0081, SELW, e);
        wr(32'hC000_0082, LENT, e);
        wr(32'hC000_0083, CENT, e);
        rd(32'hC000_0081, d, e); chk("R2 selector reg", d, SELW);
        chk("R2 no error on defined index", {63'h0, e}, 64'h0);
        rd(32'hC000_0082, d, e); chk("R2 long entry reg", d, LENT);
        rd(32'hC000_0083, d, e); chk("R2 compat entry reg", d, CENT);
    endtask

    task automatic t_fmask();
        logic [63:0] d; logic e;
        wr(32'hC000_0084, FMASK, e);
        rd(32'hC000_0084, d, e);
        chk("R4 mask upper half reserved", d, {32'h0, FMASK[31:0]});
    endtask

    task automatic t_undef();
        logic [63:0] d; logic e;
        wr(32'hC000_0085, 64'h1234, e);
        chk("R5 write error flag", {63'h0, e}, 64'h1);
        rd(32'hC000_0085, d, e);
        chk("R5 undefined read data", d, 64'h0);
        chk("R5 read error flag", {63'h0, e}, 64'h1);
        rd(32'hC000_0084, d, e);
        chk("R5 mask untouched by stray write", d, {32'h0, FMASK[31:0]});
        rd(32'hC000_0081, d, e);
        chk("R5 selector untouched by stray write", d, SELW);
    endtask

    task automatic t_feat();
        logic [63:0] d; logic e;
        pg_en = 1'b0;
        wr(32'hC000_0080, 64'hFFFF_FFFF_FFFF_FFFF, e);
        wait_cyc(2);
        rd(32'hC000_0080, d, e);
        chk("R3 writable bits only, active low without paging", d, 64'h901);
        pg_en = 1'b1;
        wait_cyc(2);
        rd(32'hC000_0080, d, e);
        chk("R3 active follows enable and paging", d, 64'hD01);
        wr(32'hC000_0080, 64'h400, e);
        wait_cyc(2);
        rd(32'hC000_0080, d, e);
        chk("R3 write to active bit ignored", d, 64'h0);
    endtask

    task automatic t_ud_disabled();
        fire(1, 0, 0);
        chk_strobes("R11 call while disabled", 0, 1, 0);
        chk_arch("R11 no change on disabled call");
    endtask

    task automatic t_enable();
        logic [63:0] d; logic e;
        wr(32'hC000_0080, 64'h101, e);
        wait_cyc(2);
        rd(32'hC000_0080, d, e);
        chk("R3 enable with long mode active", d, 64'h501);
    endtask

    task automatic t_gp();
        fire(0, 1, 1);
        chk_strobes("R12 return from ring 3", 0, 0, 1);
        chk_arch("R12 no change on ring-3 return");
    endtask

    task automatic t_call();
        ctx(64'h1234_5678_9ABC_DEF0, 64'h246, 64'h1111, 64'h2222);
        fire(1, 0, 0);
        model_call();
        chk_strobes("R13 call done pulse", 1, 0, 0);
        chk_arch("R6 R7 call");
        @(negedge clk);
        chk_strobes("R13 done is one clock", 0, 0, 0);
    endtask

    task automatic t_ret64();
        ctx(m_rip, m_fl, 64'hFFFF_8000_1234_5678, 64'hA84);
        fire(0, 1, 1);
        m_rip = m_rcx; m_fl = m_r11 | 64'h2;
        m_cs = (SELW[63:48] + 16'd16) | 16'h3;
        m_ss = (SELW[63:48] + 16'd8) | 16'h3;
        m_cpl = 2'd3;
        chk_strobes("R8 return done", 1, 0, 0);
        chk_arch("R8 R10 64-bit return");
    endtask

    task automatic t_compat();
        fire(1, 0, 0);
        model_call();
        chk_arch("R6 second call");
        fire(0, 1, 0);
        m_rip = {32'h0, m_rcx[31:0]}; m_fl = m_r11 | 64'h2;
        m_cs = SELW[63:48] | 16'h3;
        m_ss = (SELW[63:48] + 16'd8) | 16'h3;
        m_cpl = 2'd3;
        chk_arch("R9 R10 compatibility return");
    endtask

    task automatic t_prio();
        fire(1, 1, 1);
        model_call();
        chk_strobes("R13 call wins over return", 1, 0, 0);
        chk_arch("R13 simultaneous requests");
    endtask

    task automatic t_ud_lma();
        pg_en = 1'b0;
        wait_cyc(2);
        fire(0, 1, 1);
        chk_strobes("R11 return with long mode inactive", 0, 1, 0);
        chk_arch("R11 no change with long mode inactive");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_fmask();
        t_undef();
        t_feat();
        t_ud_disabled();
        t_enable();
        t_gp();
        t_call();
        t_ret64();
        t_compat();
        t_prio();
        t_ud_lma();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule